// File: doc/BRIEF.md
# MESIF Line Coherence Controller

This block keeps the coherence state of a small set of cache lines for one caching agent in a source-snooping system that uses the five MESIF states. Each line has its own state machine with two parts: the line state (Invalid, Shared, Exclusive, Forward, Modified) and a miss tracker (Idle, ReadPending, OwnPending). Three ports drive these machines:
- The local port carries read and write requests from the core. The block answers each with a hit, a read miss, an ownership miss or a retry.
- The snoop port carries read and ownership snoops from peer agents. The block answers each with one of four snoop responses and flags a write-back to home when one is needed.
- The fill port carries the home agent's completion for an outstanding miss. For a read miss the completion includes a grant that picks the installed state.

Among the sharers of a line, only the Forward holder supplies data to a read snoop. On a read snoop a Forward, Exclusive or Modified holder supplies the data and drops to Shared, and the requester then installs Forward. A Modified holder that supplies data on a read snoop also asks for a write-back. A Shared holder answers a read snoop without data. An ownership snoop invalidates every copy. Any holder other than Shared passes its data to the requester on an ownership snoop.

Named line-state transitions:
- Read miss: Invalid → Invalid with ReadPending.
- Ownership miss: Invalid, Shared or Forward → unchanged state with OwnPending.
- Write hit: Exclusive or Modified → Modified.
- Supply on read snoop: Exclusive, Forward or Modified → Shared.
- Ownership invalidate: any state → Invalid.
- Read fill: ReadPending → Shared, Forward or Exclusive, as the grant selects.
- Ownership fill: OwnPending → Modified.

Top module: `mesif_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid with no miss outstanding, and both response valids are low. State encoding on `lrsp_state`: I=3'b000, S=3'b001, E=3'b010, F=3'b011, M=3'b100.
- R2: A local read is answered one cycle after it is accepted, with `lrsp_state` giving the line state before the request. The response kind is LR_HIT (2'b00) for S, E, F or M, and the state does not change. For I the kind is LR_RD_MISS (2'b01), and the line becomes ReadPending.
- R3: A local write to an E or M line answers LR_HIT and leaves the line in M. A local write to an I, S or F line answers LR_OWN_MISS (2'b10), leaves the state unchanged and marks the line OwnPending.
- R4: A local request to a line with a miss outstanding answers LR_RETRY (2'b11) and changes neither the state nor the pending miss.
- R5: A read snoop answers as follows:
  - I: RSP_INV (2'b00), the line stays I.
  - S: RSP_SHR (2'b01), the line stays S.
  - E, F or M: RSP_FWD_S (2'b10), and the line becomes S.
- R6: An ownership snoop leaves the line I. It answers RSP_INV (2'b00) from I or S and RSP_FWD_I (2'b11) from E, F or M.
- R7: A snoop response is valid exactly one cycle after each accepted snoop. `srsp_wb` is high only for a read snoop that hits an M line.
- R8: A fill to a ReadPending line installs the state its grant selects: 2'b00 gives S, 2'b01 gives F, 2'b10 gives E, 2'b11 gives S. The fill clears the pending miss.
- R9: A fill to an OwnPending line installs M whatever the grant, and clears the pending miss.
- R10: A fill to a line with no miss outstanding changes nothing.
- R11: A snoop to a line with a miss outstanding is answered from the line's current state and does not cancel the miss. When a snoop and a fill reach the same line in one cycle, the snoop is answered from the pre-fill state and the line ends in the state the fill installs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_write | input | 1 | Local request is a write |
| lreq_idx | input | IDX_W | Line addressed by the local request |
| lrsp_valid | output | 1 | Local response valid |
| lrsp_kind | output | 2 | Hit, read miss, ownership miss or retry |
| lrsp_state | output | 3 | Line state before the request |
| snp_valid | input | 1 | Snoop present |
| snp_own | input | 1 | Snoop asks for ownership |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| srsp_valid | output | 1 | Snoop response valid |
| srsp_code | output | 2 | Snoop response code |
| srsp_wb | output | 1 | Write-back to home required |
| fill_valid | input | 1 | Fill from home present |
| fill_grant | input | 2 | Installed state for a read fill |
| fill_idx | input | IDX_W | Line addressed by the fill |

## Verification
The properties assume that a local request and a snoop never address the same line in the same cycle, and that inputs are held low while reset is asserted. The bench issues every combination of operations one cycle at a time. It puts a local request and a snoop in the same cycle only when they address different lines, and it keeps all valids low during reset. A snoop and a fill to the same line in one cycle are legal inputs and are exercised on purpose.

// File: rtl/mesif_ctrl_pkg.sv
package mesif_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'b000,
        ST_S = 3'b001,
        ST_E = 3'b010,
        ST_F = 3'b011,
        ST_M = 3'b100
    } line_st_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'b00,
        PD_RD   = 2'b01,
        PD_OWN  = 2'b10
    } pend_e;

    typedef enum logic [1:0] {
        RSP_INV   = 2'b00,
        RSP_SHR   = 2'b01,
        RSP_FWD_S = 2'b10,
        RSP_FWD_I = 2'b11
    } snp_rsp_e;

    typedef enum logic [1:0] {
        LR_HIT      = 2'b00,
        LR_RD_MISS  = 2'b01,
        LR_OWN_MISS = 2'b10,
        LR_RETRY    = 2'b11
    } lcl_rsp_e;

endpackage

// File: rtl/mesif_snoop_rules.sv
module mesif_snoop_rules
    import mesif_ctrl_pkg::*;
(
    input  line_st_e cur_st,
    input  logic     own_req,
    output snp_rsp_e rsp,
    output logic     wb_req,
    output line_st_e nxt_st
);

    always_comb begin
        rsp    = RSP_INV;
        wb_req = 1'b0;
        nxt_st = cur_st;
        unique case (cur_st)
            ST_I: begin
                rsp    = RSP_INV;
                nxt_st = ST_I;
            end
            ST_S: begin
                rsp    = own_req ? RSP_INV : RSP_SHR;
                nxt_st = own_req ? ST_I : ST_S;
            end
            ST_E, ST_F: begin
                rsp    = own_req ? RSP_FWD_I : RSP_FWD_S;
                nxt_st = own_req ? ST_I : ST_S;
            end
            ST_M: begin
                rsp    = own_req ? RSP_FWD_I : RSP_FWD_S;
                wb_req = !own_req;
                nxt_st = own_req ? ST_I : ST_S;
            end
            default: nxt_st = ST_I;
        endcase
    end

endmodule

// File: rtl/mesif_local_rules.sv
module mesif_local_rules
    import mesif_ctrl_pkg::*;
(
    input  line_st_e cur_st,
    input  pend_e    cur_pd,
    input  logic     wr_req,
    output lcl_rsp_e kind,
    output line_st_e nxt_st,
    output pend_e    nxt_pd
);

    always_comb begin
        kind   = LR_HIT;
        nxt_st = cur_st;
        nxt_pd = cur_pd;
        if (cur_pd != PD_NONE) begin
            kind = LR_RETRY;
        end else begin
            unique case (cur_st)
                ST_I: begin
                    kind   = wr_req ? LR_OWN_MISS : LR_RD_MISS;
                    nxt_pd = wr_req ? PD_OWN : PD_RD;
                end
                ST_S, ST_F: begin
                    kind   = wr_req ? LR_OWN_MISS : LR_HIT;
                    nxt_pd = wr_req ? PD_OWN : PD_NONE;
                end
                ST_E, ST_M: begin
                    kind   = LR_HIT;
                    nxt_st = wr_req ? ST_M : cur_st;
                end
                default: nxt_st = ST_I;
            endcase
        end
    end

endmodule

// File: rtl/mesif_line_fsm.sv
module mesif_line_fsm
    import mesif_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snp_sel,
    input  logic       snp_own,
    input  logic       lcl_sel,
    input  logic       lcl_wr,
    input  logic       fill_sel,
    input  logic [1:0] fill_grant,
    output line_st_e   st_q,
    output snp_rsp_e   snp_rsp,
    output logic       snp_wb,
    output lcl_rsp_e   lcl_kind
);

    pend_e    pd_q;
    pend_e    pd_d;
    line_st_e st_d;
    line_st_e snp_nxt;
    line_st_e lcl_nxt;
    pend_e    lcl_pd;
    line_st_e fill_st;

    mesif_snoop_rules u_snp (
        .cur_st  (st_q),
        .own_req (snp_own),
        .rsp     (snp_rsp),
        .wb_req  (snp_wb),
        .nxt_st  (snp_nxt)
    );

    mesif_local_rules u_lcl (
        .cur_st (st_q),
        .cur_pd (pd_q),
        .wr_req (lcl_wr),
        .kind   (lcl_kind),
        .nxt_st (lcl_nxt),
        .nxt_pd (lcl_pd)
    );

    // state installed by a completing fill
    always_comb begin
        fill_st = ST_S;
        unique case (pd_q)
            PD_OWN:  fill_st = ST_M;
            PD_RD: begin
                unique case (fill_grant)
                    2'b01:   fill_st = ST_F;
                    2'b10:   fill_st = ST_E;
                    default: fill_st = ST_S;
                endcase
            end
            default: fill_st = st_q;
        endcase
    end

    always_comb begin
        st_d = st_q;
        pd_d = pd_q;
        if (snp_sel) begin
            st_d = snp_nxt;
        end else if (lcl_sel) begin
            st_d = lcl_nxt;
            pd_d = lcl_pd;
        end
        if (fill_sel && (pd_q != PD_NONE)) begin
            st_d = fill_st;
            pd_d = PD_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_I;
            pd_q <= PD_NONE;
        end else begin
            st_q <= st_d;
            pd_q <= pd_d;
        end
    end

endmodule

// File: rtl/mesif_snoop_ctrl.sv
module mesif_snoop_ctrl
    import mesif_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lreq_valid,
    input  logic             lreq_write,
    input  logic [IDX_W-1:0] lreq_idx,
    output logic             lrsp_valid,
    output logic [1:0]       lrsp_kind,
    output logic [2:0]       lrsp_state,
    input  logic             snp_valid,
    input  logic             snp_own,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             srsp_valid,
    output logic [1:0]       srsp_code,
    output logic             srsp_wb,
    input  logic             fill_valid,
    input  logic [1:0]       fill_grant,
    input  logic [IDX_W-1:0] fill_idx
);

    line_st_e st_arr   [NUM_LINES];
    snp_rsp_e rsp_arr  [NUM_LINES];
    logic     wb_arr   [NUM_LINES];
    lcl_rsp_e kind_arr [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        mesif_line_fsm u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .snp_sel    (snp_valid && (snp_idx == IDX_W'(g))),
            .snp_own    (snp_own),
            .lcl_sel    (lreq_valid && (lreq_idx == IDX_W'(g))),
            .lcl_wr     (lreq_write),
            .fill_sel   (fill_valid && (fill_idx == IDX_W'(g))),
            .fill_grant (fill_grant),
            .st_q       (st_arr[g]),
            .snp_rsp    (rsp_arr[g]),
            .snp_wb     (wb_arr[g]),
            .lcl_kind   (kind_arr[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrsp_valid <= 1'b0;
            lrsp_kind  <= 2'b00;
            lrsp_state <= 3'b000;
            srsp_valid <= 1'b0;
            srsp_code  <= 2'b00;
            srsp_wb    <= 1'b0;
        end else begin
            lrsp_valid <= lreq_valid;
            srsp_valid <= snp_valid;
            if (lreq_valid) begin
                lrsp_kind  <= kind_arr[lreq_idx];
                lrsp_state <= st_arr[lreq_idx];
            end
            if (snp_valid) begin
                srsp_code <= rsp_arr[snp_idx];
                srsp_wb   <= wb_arr[snp_idx];
            end else begin
                srsp_wb   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mesif_snoop_ctrl_chk.sv
module mesif_snoop_ctrl_chk #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lreq_valid,
    input logic             lreq_write,
    input logic             lrsp_valid,
    input logic [1:0]       lrsp_kind,
    input logic [2:0]       lrsp_state,
    input logic             snp_valid,
    input logic             snp_own,
    input logic             srsp_valid,
    input logic [1:0]       srsp_code,
    input logic             srsp_wb
);

    // R7
    snoop_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> srsp_valid);

    // R7
    snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !srsp_valid);

    // R7
    wb_only_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srsp_valid && srsp_wb) |-> (srsp_code == 2'b10));

    // R6
    own_never_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_own) |=> ((srsp_code != 2'b01) && (srsp_code != 2'b10) && !srsp_wb));

    // R2
    read_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lreq_valid && !lreq_write) |=> (lrsp_valid && lrsp_kind != 2'b10 &&
                                         (lrsp_kind != 2'b00 || lrsp_state != 3'b000)));

    // R3
    write_hit_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lreq_valid && lreq_write) |=> (lrsp_kind != 2'b00 ||
                                        lrsp_state == 3'b010 || lrsp_state == 3'b100));

endmodule

bind mesif_snoop_ctrl mesif_snoop_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lreq_valid (lreq_valid),
    .lreq_write (lreq_write),
    .lrsp_valid (lrsp_valid),
    .lrsp_kind  (lrsp_kind),
    .lrsp_state (lrsp_state),
    .snp_valid  (snp_valid),
    .snp_own    (snp_own),
    .srsp_valid (srsp_valid),
    .srsp_code  (srsp_code),
    .srsp_wb    (srsp_wb)
);

// File: tb/mesif_snoop_ctrl_tb.sv
module mesif_snoop_ctrl_tb;

    localparam int NL = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lreq_valid = 1'b0, lreq_write = 1'b0;
    logic [IW-1:0] lreq_idx = '0;
    logic          lrsp_valid;
    logic [1:0]    lrsp_kind;
    logic [2:0]    lrsp_state;
    logic          snp_valid = 1'b0, snp_own = 1'b0;
    logic [IW-1:0] snp_idx = '0;
    logic          srsp_valid;
    logic [1:0]    srsp_code;
    logic          srsp_wb;
    logic          fill_valid = 1'b0;
    logic [1:0]    fill_grant = 2'b00;
    logic [IW-1:0] fill_idx = '0;

    int n_chk = 0;
    int n_bad = 0;
    int m_st [NL];
    int m_pd [NL];

    always #4 clk = ~clk;

    mesif_snoop_ctrl #(.NUM_LINES(NL)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; expectations from the requirement tables
    task automatic cycle(input bit lv, input bit lw, input int li,
                         input bit sv, input bit so, input int si,
                         input bit fv, input int fg, input int fi,
                         input string note);
        int e_kind, e_lst, e_code, s_nxt, l_nxt, l_pd;
        bit e_wb;
        int pre_st [NL];
        int pre_pd [NL];
        string ltag, stag;
        for (int k = 0; k < NL; k++) begin pre_st[k] = m_st[k]; pre_pd[k] = m_pd[k]; end
        // local expectation (R2, R3, R4)
        e_lst = pre_st[li]; l_nxt = pre_st[li]; l_pd = pre_pd[li];
        if (pre_pd[li] != 0) e_kind = 3;
        else if (pre_st[li] == 0) begin e_kind = lw ? 2 : 1; l_pd = lw ? 2 : 1; end
        else if (lw && (pre_st[li] == 1 || pre_st[li] == 3)) begin e_kind = 2; l_pd = 2; end
        else begin e_kind = 0; if (lw) l_nxt = 4; end
        ltag = (pre_pd[li] != 0) ? "R4" : (lw ? "R3" : "R2");
        // snoop expectation (R5, R6, R7)
        e_wb = 1'b0;
        if (pre_st[si] == 0) begin e_code = 0; s_nxt = 0; end
        else if (so) begin e_code = (pre_st[si] == 1) ? 0 : 3; s_nxt = 0; end
        else begin e_code = (pre_st[si] == 1) ? 1 : 2; s_nxt = 1; e_wb = (pre_st[si] == 4); end
        stag = so ? "R6" : "R5";
        // model update: snoop, then local, then fill over both
        if (sv) m_st[si] = s_nxt;
        if (lv && !(sv && si == li)) begin m_st[li] = l_nxt; m_pd[li] = l_pd; end
        if (fv && pre_pd[fi] != 0) begin
            if (pre_pd[fi] == 2) m_st[fi] = 4;
            else m_st[fi] = (fg == 1) ? 3 : ((fg == 2) ? 2 : 1);
            m_pd[fi] = 0;
        end
        lreq_valid = lv; lreq_write = lw; lreq_idx = IW'(li);
        snp_valid = sv; snp_own = so; snp_idx = IW'(si);
        fill_valid = fv; fill_grant = 2'(fg); fill_idx = IW'(fi);
        @(negedge clk);
        lreq_valid = 1'b0; snp_valid = 1'b0; fill_valid = 1'b0;
        chk(lrsp_valid == lv, {"R2 lrsp_valid ", note}, int'(lrsp_valid), int'(lv));
        if (lv) begin
            chk(lrsp_kind == 2'(e_kind), {ltag, " kind ", note}, int'(lrsp_kind), e_kind);
            chk(lrsp_state == 3'(e_lst), {ltag, " state ", note}, int'(lrsp_state), e_lst);
        end
        chk(srsp_valid == sv, {"R7 srsp_valid ", note}, int'(srsp_valid), int'(sv));
        if (sv) begin
            chk(srsp_code == 2'(e_code), {stag, " code ", note}, int'(srsp_code), e_code);
            chk(srsp_wb == e_wb, {"R7 wb ", note}, int'(srsp_wb), int'(e_wb));
        end else begin
            chk(srsp_wb == 1'b0, {"R7 wb idle ", note}, int'(srsp_wb), 0);
        end
    endtask

    task automatic lrd(input int li, input string note);
        cycle(1, 0, li, 0, 0, 0, 0, 0, 0, note);
    endtask

    // bring a line to state st with nothing pending
    task automatic setup(input int li, input int st);
        if (m_pd[li] != 0) cycle(0, 0, 0, 0, 0, 0, 1, 0, li, "R8 R9 drain");
        cycle(0, 0, 0, 1, 1, li, 0, 0, 0, "R6 clear");
        case (st)
            1: begin lrd(li, "R2 setup"); cycle(0, 0, 0, 0, 0, 0, 1, 0, li, "R8 S"); end
            2: begin lrd(li, "R2 setup"); cycle(0, 0, 0, 0, 0, 0, 1, 2, li, "R8 E"); end
            3: begin lrd(li, "R2 setup"); cycle(0, 0, 0, 0, 0, 0, 1, 1, li, "R8 F"); end
            4: begin cycle(1, 1, li, 0, 0, 0, 0, 0, 0, "R3 setup");
                     cycle(0, 0, 0, 0, 0, 0, 1, 1, li, "R9 M"); end
            default: ;
        endcase
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < NL; k++) begin m_st[k] = 0; m_pd[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk(lrsp_valid == 1'b0, "R1 lrsp_valid in reset", int'(lrsp_valid), 0);
        chk(srsp_valid == 1'b0, "R1 srsp_valid in reset", int'(srsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every line reads as I with a fresh read miss
        for (int k = 0; k < NL; k++) lrd(k, "R1 reset probe");
        for (int k = 0; k < NL; k++) cycle(0, 0, 0, 0, 0, 0, 1, 0, k, "R8 drain");

        // sweep: every line, every start state, every single operation, then probe
        for (int li = 0; li < NL; li++) begin
            for (int st = 0; st < 5; st++) begin
                for (int op = 0; op < 6; op++) begin
                    setup(li, st);
                    case (op)
                        0: lrd(li, "R2 sweep");
                        1: cycle(1, 1, li, 0, 0, 0, 0, 0, 0, "R3 sweep");
                        2: cycle(0, 0, 0, 1, 0, li, 0, 0, 0, "R5 sweep");
                        3: cycle(0, 0, 0, 1, 1, li, 0, 0, 0, "R6 sweep");
                        4: cycle(0, 0, 0, 0, 0, 0, 1, 1, li, "R10 stray fill");
                        default: cycle(1, 0, (li + 1) % NL, 1, 0, li, 0, 0, 0, "R5 concurrent");
                    endcase
                    lrd(li, "R10 probe");
                end
            end
        end

        // R8: every grant code on a read miss
        for (int g = 0; g < 4; g++) begin
            setup(1, 0);
            lrd(1, "R8 miss");
            cycle(0, 0, 0, 0, 0, 0, 1, g, 1, "R8 fill");
            lrd(1, "R8 probe");
        end
        // R9: every grant on an ownership miss from I, S and F
        for (int st = 0; st < 4; st += 1) begin
            if (st == 2) continue;
            for (int g = 0; g < 4; g++) begin
                setup(2, st);
                cycle(1, 1, 2, 0, 0, 0, 0, 0, 0, "R9 own miss");
                cycle(0, 0, 0, 0, 0, 0, 1, g, 2, "R9 fill");
                lrd(2, "R9 probe");
            end
        end
        // R4: retries while pending
        setup(0, 1);
        cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, "R4 own miss");
        lrd(0, "R4 retry read");
        cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, "R4 retry write");
        // R11: snoops while pending, answered from current state
        cycle(0, 0, 0, 1, 0, 0, 0, 0, 0, "R11 read snoop pending");
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R11 fill after snoop");
        lrd(0, "R11 probe M");
        setup(3, 0);
        lrd(3, "R11 read miss");
        cycle(0, 0, 0, 1, 1, 3, 0, 0, 0, "R11 own snoop pending");
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 3, "R11 fill F");
        lrd(3, "R11 probe F");
        // R11: snoop and fill to the same line in one cycle
        for (int so = 0; so < 2; so++) begin
            setup(1, 3);
            cycle(1, 1, 1, 0, 0, 0, 0, 0, 0, "R11 own miss on F");
            cycle(0, 0, 0, 1, so[0], 1, 1, 0, 1, "R11 same cycle");
            lrd(1, "R11 probe after same cycle");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule